// File: doc/BRIEF.md
# ECP Host Link Direction Turnaround Controller

This block sits on the host side of an IEEE 1284 ECP parallel link and performs the two bus turnarounds: from the forward direction into reverse idle, and from reverse idle back into the forward ECP phase. It owns the 3-bit port mode field, the data direction bit and the reverse-request line. It watches the peripheral status lines and, before it leaves ECP mode on the way back to forward, moves any bytes left in the receive FIFO into an 8-entry shadow buffer. Software can read that buffer afterwards through its own port. A mode change clears the receive FIFO, so nothing is lost unless the shadow buffer overflows.

Each wait on the peripheral has a timeout. The timeout is a down-counter that is loaded from `wait_limit_i` when the wait starts. When a wait expires, or the shadow buffer fills while the FIFO still holds data, the block runs a fixed recovery: it releases the request, takes the handshake lines back from the ECP engine, goes to PS/2 mode and sets the direction to write. It then parks in forward idle with a sticky error flag raised.

Top module: `ecp_turn_ctrl`

## Requirements
- R1: After reset, mode_o is 001 (PS/2), dir_read_o is 0, rev_req_n_o is 1, hs_engine_o is 0, phase_o is 00 (forward idle), both error flags are 0 and the shadow buffer is empty.
- R2: Mode codes are 001 for PS/2 and 011 for ECP with DMA off. dir_read_o changes only on a cycle where mode_o was already 001.
- R3: A go-reverse command in forward idle does the following in order: set mode 001, set dir_read_o to 1, drive rev_req_n_o low, then wait for ack_rev_n_i low. When that succeeds, mode_o becomes 011, hs_engine_o becomes 1 and phase_o becomes 10 (reverse idle).
- R4: A wait loaded with limit N succeeds if its condition is seen in any of the first N+1 wait cycles. Otherwise link_fail_o goes to 1 and recovery runs: rev_req_n_o 1, hs_engine_o 0, mode 001, dir_read_o 0, phase_o 00.
- R5: A go-forward command in reverse idle drives rev_req_n_o high. It then waits, under the timeout of R4, for periph_ack_i low, periph_clk_i high and ack_rev_n_i high all at once.
- R6: After that wait, the block pops the receive FIFO (fifo_rd_o, with data valid in the same cycle) into the shadow buffer while fifo_empty_i is 0. The shadow buffer returns the bytes in arrival order on shadow_data_o, and each shadow_rd_i pulse advances it.
- R7: If the shadow buffer holds 8 bytes while the FIFO is still not empty, overflow_o goes to 1, no further byte is taken and recovery runs. Mode leaves 011 with the FIFO not empty only when an error flag is set.
- R8: After a clean drain, hs_engine_o drops to 0 (host holds both handshake lines high), mode goes to 001, dir_read_o to 0, and mode back to 011. phase_o then reads 01 (forward ECP).
- R9: A go-reverse command in forward ECP first waits, under the timeout, for fifo_empty_i. mode_o stays 011 until then, and the reverse entry of R3 follows.
- R10: go-forward is ignored outside reverse idle, go-reverse is ignored in reverse idle, and both are ignored while phase_o is 11 (turnaround in progress).
- R11: Both error flags are sticky and clear when the next command is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cmd_rev_i | input | 1 | Go-reverse command pulse |
| cmd_fwd_i | input | 1 | Go-forward command pulse |
| wait_limit_i | input | 16 | Timeout limit loaded at the start of each wait |
| periph_ack_i | input | 1 | Peripheral acknowledge status line |
| periph_clk_i | input | 1 | Peripheral clock status line |
| ack_rev_n_i | input | 1 | Peripheral reverse acknowledge, active low |
| mode_o | output | 3 | Port mode field |
| dir_read_o | output | 1 | Data direction, 1 = host reads |
| rev_req_n_o | output | 1 | Reverse request, active low |
| hs_engine_o | output | 1 | 1 = ECP engine drives host clock/ack; 0 = host holds them high |
| fifo_empty_i | input | 1 | Receive FIFO empty flag |
| fifo_data_i | input | 8 | Receive FIFO head byte |
| fifo_rd_o | output | 1 | Receive FIFO pop |
| shadow_rd_i | input | 1 | Shadow buffer pop |
| shadow_data_o | output | 8 | Shadow buffer head byte |
| shadow_empty_o | output | 1 | Shadow buffer empty |
| shadow_count_o | output | 4 | Shadow buffer fill level |
| phase_o | output | 2 | 00 fwd idle, 01 fwd ECP, 10 rev idle, 11 moving |
| link_fail_o | output | 1 | Sticky timeout error |
| overflow_o | output | 1 | Sticky shadow overflow error |

## Verification
The hardest case to reach is the shadow overflow. It needs a reverse phase that completed cleanly, a FIFO holding more bytes than the shadow buffer can take, and a peripheral that gives the full exit status combination on time. The bench loads ten bytes into its FIFO model while the link sits in reverse idle, where the block never pops. It answers the released request with the exact exit combination, then checks that eight bytes came across in order and two stayed behind. The timeout boundary is driven by delaying the acknowledge to exactly the last allowed wait cycle, and then to one cycle later.

// File: rtl/ecp_turn_pkg.sv
package ecp_turn_pkg;
  typedef enum logic [2:0] {
    MODE_COMPAT = 3'b000,
    MODE_PS2    = 3'b001,
    MODE_ECP    = 3'b011
  } ecp_mode_e;

  typedef enum logic [1:0] {
    PH_FWD_IDLE = 2'b00,
    PH_FWD_ECP  = 2'b01,
    PH_REV_IDLE = 2'b10,
    PH_MOVING   = 2'b11
  } ecp_phase_e;

  typedef enum logic [4:0] {
    S_FIDLE, S_FECP, S_REV,
    S_FDRAIN,
    S_R_PS2, S_R_DIR, S_R_REQ, S_R_WAIT, S_R_ECP,
    S_X_REL, S_X_WAIT, S_X_DRAIN, S_X_HS, S_X_PS2, S_X_DIR, S_X_ECP,
    S_RC_PS2, S_RC_DIR
  } turn_state_e;
endpackage

// File: rtl/ecp_wait_timer.sv
module ecp_wait_timer #(
  parameter int TW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [TW-1:0] limit,
  input  logic          run,
  output logic          expired
);
  logic [TW-1:0] cnt_q;

  function automatic logic [TW-1:0] count_down(input logic [TW-1:0] v);
    return (v == '0) ? v : v - 1'b1;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt_q <= '0;
    else if (load) cnt_q <= limit;
    else if (run)  cnt_q <= count_down(cnt_q);
  end

  assign expired = (cnt_q == '0);

  // R4: a running count never wraps upward
  assert_timer_monotonic_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $past(run) && !$past(load) |-> cnt_q <= $past(cnt_q));
endmodule

// File: rtl/ecp_shadow_buf.sv
module ecp_shadow_buf #(
  parameter int DEPTH = 8,
  parameter int DW    = 8,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [DW-1:0] din,
  input  logic          pop,
  output logic [DW-1:0] dout,
  output logic [CW-1:0] count,
  output logic          full,
  output logic          empty
);
  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wr_q, rd_q;
  logic [CW-1:0] cnt_q;
  logic          do_pop;

  function automatic logic [AW-1:0] ptr_inc(input logic [AW-1:0] p);
    return (int'(p) == DEPTH - 1) ? '0 : p + 1'b1;
  endfunction

  assign do_pop = pop && !empty;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (push)   wr_q <= ptr_inc(wr_q);
      if (do_pop) rd_q <= ptr_inc(rd_q);
      cnt_q <= cnt_q + CW'(push) - CW'(do_pop);
    end
  end

  always_ff @(posedge clk) begin
    if (push) mem[wr_q] <= din;
  end

  assign dout  = mem[rd_q];
  assign count = cnt_q;
  assign full  = (int'(cnt_q) == DEPTH);
  assign empty = (cnt_q == '0);

  // R7: nothing is ever written into a full shadow buffer
  assert_no_push_full_R7: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> !full);
endmodule

// File: rtl/ecp_turn_ctrl.sv
module ecp_turn_ctrl #(
  parameter int TIMER_W      = 16,
  parameter int SHADOW_DEPTH = 8,
  parameter int DATA_W       = 8,
  localparam int CW          = $clog2(SHADOW_DEPTH + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cmd_rev_i,
  input  logic               cmd_fwd_i,
  input  logic [TIMER_W-1:0] wait_limit_i,
  input  logic               periph_ack_i,
  input  logic               periph_clk_i,
  input  logic               ack_rev_n_i,
  output logic [2:0]         mode_o,
  output logic               dir_read_o,
  output logic               rev_req_n_o,
  output logic               hs_engine_o,
  input  logic               fifo_empty_i,
  input  logic [DATA_W-1:0]  fifo_data_i,
  output logic               fifo_rd_o,
  input  logic               shadow_rd_i,
  output logic [DATA_W-1:0]  shadow_data_o,
  output logic               shadow_empty_o,
  output logic [CW-1:0]      shadow_count_o,
  output logic [1:0]         phase_o,
  output logic               link_fail_o,
  output logic               overflow_o
);
  import ecp_turn_pkg::*;

  turn_state_e state_q;
  ecp_mode_e   mode_q;
  logic        dir_q, req_n_q, hs_q, fail_q, ovf_q;
  logic        tmr_load, tmr_run, tmr_expired;
  logic        sh_full, wait_state, wait_met;

  function automatic logic exit_combo(input logic pack, input logic pclk, input logic arn);
    return !pack && pclk && arn;
  endfunction

  function automatic ecp_phase_e phase_of(input turn_state_e s);
    case (s)
      S_FIDLE: return PH_FWD_IDLE;
      S_FECP:  return PH_FWD_ECP;
      S_REV:   return PH_REV_IDLE;
      default: return PH_MOVING;
    endcase
  endfunction

  assign wait_state = (state_q == S_FDRAIN) || (state_q == S_R_WAIT) || (state_q == S_X_WAIT);
  always_comb begin
    case (state_q)
      S_FDRAIN: wait_met = fifo_empty_i;
      S_R_WAIT: wait_met = !ack_rev_n_i;
      S_X_WAIT: wait_met = exit_combo(periph_ack_i, periph_clk_i, ack_rev_n_i);
      default:  wait_met = 1'b0;
    endcase
  end

  assign tmr_load = (state_q == S_R_REQ) || (state_q == S_X_REL) ||
                    (state_q == S_FECP && cmd_rev_i);
  assign tmr_run  = wait_state && !wait_met;

  ecp_wait_timer #(.TW(TIMER_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .load(tmr_load), .limit(wait_limit_i),
    .run(tmr_run), .expired(tmr_expired)
  );

  assign fifo_rd_o = (state_q == S_X_DRAIN) && !fifo_empty_i && !sh_full;

  ecp_shadow_buf #(.DEPTH(SHADOW_DEPTH), .DW(DATA_W)) u_shadow (
    .clk(clk), .rst_n(rst_n), .push(fifo_rd_o), .din(fifo_data_i),
    .pop(shadow_rd_i), .dout(shadow_data_o), .count(shadow_count_o),
    .full(sh_full), .empty(shadow_empty_o)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_FIDLE;
      mode_q  <= MODE_PS2;
      dir_q   <= 1'b0;
      req_n_q <= 1'b1;
      hs_q    <= 1'b0;
      fail_q  <= 1'b0;
      ovf_q   <= 1'b0;
    end else begin
      case (state_q)
        S_FIDLE: if (cmd_rev_i) begin
          fail_q <= 1'b0; ovf_q <= 1'b0; state_q <= S_R_PS2;
        end
        S_FECP: if (cmd_rev_i) begin
          fail_q <= 1'b0; ovf_q <= 1'b0; state_q <= S_FDRAIN;
        end
        S_REV: if (cmd_fwd_i) begin
          fail_q <= 1'b0; ovf_q <= 1'b0; state_q <= S_X_REL;
        end
        S_FDRAIN, S_R_WAIT, S_X_WAIT: begin
          if (wait_met) begin
            case (state_q)
              S_FDRAIN: state_q <= S_R_PS2;
              S_R_WAIT: state_q <= S_R_ECP;
              default:  state_q <= S_X_DRAIN;
            endcase
          end else if (tmr_expired) begin
            fail_q <= 1'b1; state_q <= S_RC_PS2;
          end
        end
        S_R_PS2: begin mode_q <= MODE_PS2; state_q <= S_R_DIR; end
        S_R_DIR: begin dir_q <= 1'b1; state_q <= S_R_REQ; end
        S_R_REQ: begin req_n_q <= 1'b0; state_q <= S_R_WAIT; end
        S_R_ECP: begin mode_q <= MODE_ECP; hs_q <= 1'b1; state_q <= S_REV; end
        S_X_REL: begin req_n_q <= 1'b1; state_q <= S_X_WAIT; end
        S_X_DRAIN: begin
          if (fifo_empty_i) state_q <= S_X_HS;
          else if (sh_full) begin ovf_q <= 1'b1; state_q <= S_RC_PS2; end
        end
        S_X_HS:  begin hs_q <= 1'b0; state_q <= S_X_PS2; end
        S_X_PS2: begin mode_q <= MODE_PS2; state_q <= S_X_DIR; end
        S_X_DIR: begin dir_q <= 1'b0; state_q <= S_X_ECP; end
        S_X_ECP: begin mode_q <= MODE_ECP; state_q <= S_FECP; end
        S_RC_PS2: begin
          req_n_q <= 1'b1; hs_q <= 1'b0; mode_q <= MODE_PS2; state_q <= S_RC_DIR;
        end
        S_RC_DIR: begin dir_q <= 1'b0; state_q <= S_FIDLE; end
        default: state_q <= S_FIDLE;
      endcase
    end
  end

  assign mode_o      = mode_q;
  assign dir_read_o  = dir_q;
  assign rev_req_n_o = req_n_q;
  assign hs_engine_o = hs_q;
  assign phase_o     = phase_of(state_q);
  assign link_fail_o = fail_q;
  assign overflow_o  = ovf_q;

  // R2: direction only flips while the port already sits in PS/2 mode
  assert_dir_in_ps2_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (dir_read_o != $past(dir_read_o)) |-> $past(mode_o) == MODE_PS2);

  // R3: reverse request is only active with the host off the data lines
  assert_req_needs_read_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !rev_req_n_o |-> dir_read_o);

  // R3: the ECP engine only owns the handshake in ECP mode, reading
  assert_engine_in_ecp_R3: assert property (@(posedge clk) disable iff (!rst_n)
    hs_engine_o |-> (mode_o == MODE_ECP) && dir_read_o);

  // R4: a link failure is raised only by an expired timer
  assert_fail_from_timer_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(link_fail_o) |-> $past(tmr_expired));

  // R7: leaving ECP with data still queued happens only with an error flagged
  assert_no_silent_loss_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(mode_o) == MODE_ECP) && (mode_o != MODE_ECP) && !$past(fifo_empty_i)
      |-> link_fail_o || overflow_o);

  // R10: go-forward in forward idle leaves the block in forward idle
  assert_ignore_fwd_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == S_FIDLE) && !cmd_rev_i |=> state_q == S_FIDLE);
endmodule

// File: tb/ecp_turn_ctrl_test.sv
`timescale 1ns/1ps
module ecp_turn_ctrl_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_rev = 1'b0, cmd_fwd = 1'b0;
  logic [15:0] limit = 16'd3;
  logic        p_ack = 1'b1, p_clk = 1'b0, arn = 1'b1;
  logic [2:0]  mode;
  logic        dir_rd, req_n, hs_eng, f_rd, sh_rd = 1'b0, sh_empty, lfail, ovf;
  logic [7:0]  sh_data;
  logic [3:0]  sh_cnt;
  logic [1:0]  phase;
  logic [7:0]  fmem [16];
  int          f_head = 0, f_cnt = 0;
  logic        f_empty;
  logic [7:0]  f_data;
  int          checks = 0, fails = 0;
  bit          done = 1'b0;

  always #2.5 clk = ~clk;

  assign f_empty = (f_cnt == 0);
  assign f_data  = fmem[f_head % 16];

  ecp_turn_ctrl uut (
    .clk(clk), .rst_n(rst_n), .cmd_rev_i(cmd_rev), .cmd_fwd_i(cmd_fwd),
    .wait_limit_i(limit), .periph_ack_i(p_ack), .periph_clk_i(p_clk),
    .ack_rev_n_i(arn), .mode_o(mode), .dir_read_o(dir_rd), .rev_req_n_o(req_n),
    .hs_engine_o(hs_eng), .fifo_empty_i(f_empty), .fifo_data_i(f_data),
    .fifo_rd_o(f_rd), .shadow_rd_i(sh_rd), .shadow_data_o(sh_data),
    .shadow_empty_o(sh_empty), .shadow_count_o(sh_cnt), .phase_o(phase),
    .link_fail_o(lfail), .overflow_o(ovf)
  );

  // receive FIFO model: a pop requested in a cycle takes effect after that edge
  initial forever begin
    bit pend;
    @(negedge clk);
    pend = f_rd;
    @(posedge clk);
    #1;
    if (pend) begin f_head++; f_cnt--; end
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic pulse_rev();
    cmd_rev = 1'b1; @(negedge clk); cmd_rev = 1'b0;
  endtask
  task automatic pulse_fwd();
    cmd_fwd = 1'b1; @(negedge clk); cmd_fwd = 1'b0;
  endtask
  task automatic wait_req(input logic v);
    for (int i = 0; i < 50; i++) begin
      if (req_n == v) break;
      @(negedge clk);
    end
  endtask
  task automatic settle();
    for (int i = 0; i < 300; i++) begin
      @(negedge clk);
      if (phase != 2'b11) break;
    end
  endtask
  task automatic load_fifo(input int n, input int base);
    f_head = 0; f_cnt = n;
    for (int i = 0; i < n; i++) fmem[i] = 8'(base + 7 * i);
  endtask
  task automatic read_shadow(input int n, input int base, input string tag);
    for (int i = 0; i < n; i++) begin
      chk(tag, sh_data, 8'(base + 7 * i));
      sh_rd = 1'b1; @(negedge clk); sh_rd = 1'b0;
    end
    chk(tag, sh_empty, 1);
  endtask

  task automatic t_reset();
    chk("R1 mode", mode, 1);        chk("R1 dir", dir_rd, 0);
    chk("R1 req", req_n, 1);        chk("R1 engine", hs_eng, 0);
    chk("R1 phase", phase, 0);      chk("R1 flags", {lfail, ovf}, 0);
    chk("R1 shadow", sh_empty, 1);
  endtask

  // enter reverse; ack arrives j wait cycles after the first one
  task automatic t_enter(input int j, input bit expect_ok, input string tag);
    pulse_rev();
    wait_req(1'b0);
    chk({tag, " dir read before wait"}, dir_rd, 1);
    chk({tag, " ps2 before wait"}, mode, 1);
    repeat (j) @(negedge clk);
    arn = 1'b0;
    settle();
    if (expect_ok) begin
      chk({tag, " phase"}, phase, 2);   chk({tag, " mode"}, mode, 3);
      chk({tag, " engine"}, hs_eng, 1); chk({tag, " fail"}, lfail, 0);
    end else begin
      chk({tag, " fail"}, lfail, 1);    chk({tag, " phase"}, phase, 0);
      chk({tag, " mode"}, mode, 1);     chk({tag, " dir"}, dir_rd, 0);
      chk({tag, " req"}, req_n, 1);     chk({tag, " engine"}, hs_eng, 0);
      arn = 1'b1;
    end
  endtask

  // exit reverse with n bytes queued; good selects the full status combination
  task automatic t_exit(input int n, input bit good, input string tag);
    load_fifo(n, 16 + n);
    pulse_fwd();
    wait_req(1'b1);
    arn = 1'b1; p_ack = 1'b0; p_clk = good;
    settle();
    if (good) begin
      chk({tag, " phase"}, phase, 1);   chk({tag, " mode"}, mode, 3);
      chk({tag, " dir"}, dir_rd, 0);    chk({tag, " engine"}, hs_eng, 0);
      chk({tag, " count"}, sh_cnt, n);  chk({tag, " fifo drained"}, f_cnt, 0);
      read_shadow(n, 16 + n, {tag, " order"});
    end else begin
      chk({tag, " fail"}, lfail, 1);    chk({tag, " phase"}, phase, 0);
      chk({tag, " mode"}, mode, 1);     chk({tag, " dir"}, dir_rd, 0);
      chk({tag, " no pop"}, f_cnt, n);
      f_cnt = 0;
    end
    p_ack = 1'b1; p_clk = 1'b0;
  endtask

  task automatic t_overflow();
    load_fifo(10, 40);
    pulse_fwd();
    wait_req(1'b1);
    arn = 1'b1; p_ack = 1'b0; p_clk = 1'b1;
    settle();
    chk("R7 overflow flag", ovf, 1);   chk("R7 phase", phase, 0);
    chk("R7 mode", mode, 1);           chk("R7 dir", dir_rd, 0);
    chk("R7 shadow count", sh_cnt, 8); chk("R7 left in fifo", f_cnt, 2);
    read_shadow(8, 40, "R6 overflow order");
    f_cnt = 0; p_ack = 1'b1; p_clk = 1'b0;
  endtask

  task automatic t_ignore_rev_in_rev();
    pulse_rev();
    repeat (4) @(negedge clk);
    chk("R10 rev ignored phase", phase, 2);
    chk("R10 rev ignored req", req_n, 0);
  endtask

  task automatic t_ignore_fwd(input int exp_phase, input string tag);
    pulse_fwd();
    repeat (4) @(negedge clk);
    chk({tag, " phase"}, phase, exp_phase);
    chk({tag, " req"}, req_n, 1);
  endtask

  task automatic t_fwd_drain_then_rev();
    limit = 16'd20;
    f_head = 0; f_cnt = 2;
    pulse_rev();
    repeat (6) @(negedge clk);
    chk("R9 held in ECP", mode, 3);
    chk("R9 moving", phase, 3);
    chk("R9 dir kept", dir_rd, 0);
    f_cnt = 0;
    wait_req(1'b0);
    arn = 1'b0;
    settle();
    chk("R9 reached reverse", phase, 2);
    chk("R9 mode", mode, 3);
    limit = 16'd3;
  endtask

  initial begin
    #(5.0 * 100000);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_ignore_fwd(0, "R10 fwd ignored in idle");
    t_enter(0, 1'b1, "R3 enter");
    t_ignore_rev_in_rev();
    t_exit(3, 1'b1, "R8 exit");
    t_ignore_fwd(1, "R10 fwd ignored in fwd ECP");
    t_fwd_drain_then_rev();
    t_exit(2, 1'b0, "R5 bad combo");
    t_enter(4, 1'b0, "R4 late ack");
    t_enter(3, 1'b1, "R4 last cycle ack");
    chk("R11 fail cleared", lfail, 0);
    t_overflow();
    t_enter(0, 1'b1, "R3 re-enter");
    chk("R11 overflow cleared", ovf, 0);
    t_exit(0, 1'b1, "R8 empty exit");
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule